// File: doc/BRIEF.md
# Debug Sync Pulse Responder

This block sits on the target side of a single-wire debug line and answers the host's speed-calibration request. It watches the synchronized line level on every debug-clock edge. A request is a low level held far longer than any bit of normal traffic. When it sees one, the block waits for the host to let the line rise again. It then holds off for a short guard interval, pulls the line low for an exact number of debug-clock cycles, and drives one active high cycle to sharpen the rising edge. After that it releases the pin. The host times the low pulse and derives the target's debug clock rate from it.

The controller has five states. `RS_IDLE` watches the line. `RS_WAIT_HIGH` waits for the request to end. `RS_GUARD` holds off while the host lets go of the line. `RS_PULSE` drives the line low. `RS_SPEEDUP` drives it high for one cycle. The transitions are:

| Name | From | To | Condition |
|---|---|---|---|
| detect | `RS_IDLE` | `RS_WAIT_HIGH` | the low-run meter has reached `DETECT_CYCLES` |
| line_up | `RS_WAIT_HIGH` | `RS_GUARD` | high line sample; guard timer loaded |
| guard_done | `RS_GUARD` | `RS_PULSE` | guard timer expired; pulse timer loaded |
| pulse_done | `RS_PULSE` | `RS_SPEEDUP` | pulse timer expired |
| release | `RS_SPEEDUP` | `RS_IDLE` | always, after one cycle |

In every other case the state holds. The low-run meter counts only in `RS_IDLE`, so the block takes no notice of line activity while it answers.

Top module: `dbg_sync_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pin_oe` and `sync_seen` are 0. Reset is asynchronous and active low.
- R2: A run of fewer than `DETECT_CYCLES` consecutive low samples causes no `sync_seen` and no drive.
- R3: `sync_seen` is high for exactly one cycle. That cycle directly follows the `DETECT_CYCLES`-th consecutive low sample. If the low is counted from cycle 1, `sync_seen` is high in cycle `DETECT_CYCLES+1`.
- R4: After a request is recognized, nothing is driven while the line stays low, however long that lasts.
- R5: Let cycle W be the first cycle in which the responder waits for the line and the line is sampled high. W is max(L+1, `DETECT_CYCLES`+2) for a low run of L cycles. Cycles W+1 to W+`GUARD_CYCLES` are undriven.
- R6: Next, `pin_oe`=1 and `pin_out`=0 for exactly `PULSE_CYCLES` cycles.
- R7: Next, `pin_oe`=1 and `pin_out`=1 for exactly one cycle. After that, `pin_oe` returns to 0 and the block is idle again.
- R8: Line activity during the guard, low-pulse and speed-up phases has no effect. This includes a low run longer than `DETECT_CYCLES`. Timing is unchanged and no `sync_seen` is raised.
- R9: Any high sample restarts the low-run count. Two short runs separated by a single high cycle do not add up to a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Synchronized level of the debug line |
| pin_oe | output | 1 | Output enable for the debug pin (1 = driven) |
| pin_out | output | 1 | Value driven when `pin_oe` is 1 |
| sync_seen | output | 1 | One-cycle strobe when a request is recognized |

## Verification
The hardest point to reach is the seam between recognition and the host's release. The timeline changes shape depending on whether the line rises in the detection cycle itself or later. A second hard point is a host that keeps disturbing the line during the response. The bench sweeps the low-run length from one cycle up to several cycles past the threshold. This covers the exact-threshold case, where the wait state sees a high sample at once. Separate runs hold the line low, or toggle it, through the whole response, and every cycle is compared against an arithmetically derived timeline.

// File: rtl/dbg_sync_pkg.sv
package dbg_sync_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_WAIT_HIGH,
        RS_GUARD,
        RS_PULSE,
        RS_SPEEDUP
    } resp_state_t;

endpackage

// File: rtl/dbg_low_run_meter.sv
module dbg_low_run_meter #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_in,
    output logic long_low
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!enable || line_in) begin
            run_cnt <= '0;
        end else if (run_cnt != LIMIT_V) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign long_low = (run_cnt == LIMIT_V);
endmodule

// File: rtl/dbg_phase_timer.sv
module dbg_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/dbg_sync_responder.sv
module dbg_sync_responder
    import dbg_sync_pkg::*;
#(
    parameter int DETECT_CYCLES = 128,
    parameter int GUARD_CYCLES  = 16,
    parameter int PULSE_CYCLES  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic pin_oe,
    output logic pin_out,
    output logic sync_seen
);
    localparam int LONGEST = (GUARD_CYCLES > PULSE_CYCLES) ? GUARD_CYCLES : PULSE_CYCLES;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] GUARD_LOAD = TW'(GUARD_CYCLES - 1);
    localparam logic [TW-1:0] PULSE_LOAD = TW'(PULSE_CYCLES - 1);

    resp_state_t state_q, state_d;
    logic        long_low;
    logic        tmr_load;
    logic [TW-1:0] tmr_val;
    logic        tmr_done;

    dbg_low_run_meter #(.LIMIT(DETECT_CYCLES)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state_q == RS_IDLE),
        .line_in  (line_in),
        .long_low (long_low)
    );

    dbg_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = GUARD_LOAD;
        unique case (state_q)
            RS_IDLE: begin
                if (long_low) state_d = RS_WAIT_HIGH;
            end
            RS_WAIT_HIGH: begin
                if (line_in) begin
                    state_d  = RS_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = GUARD_LOAD;
                end
            end
            RS_GUARD: begin
                if (tmr_done) begin
                    state_d  = RS_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            RS_PULSE: begin
                if (tmr_done) state_d = RS_SPEEDUP;
            end
            RS_SPEEDUP: begin
                state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pin_oe    = 1'b0;
        pin_out   = 1'b1;
        sync_seen = 1'b0;
        unique case (state_q)
            RS_IDLE:      sync_seen = long_low;
            RS_WAIT_HIGH: ;
            RS_GUARD:     ;
            RS_PULSE: begin
                pin_oe  = 1'b1;
                pin_out = 1'b0;
            end
            RS_SPEEDUP: begin
                pin_oe  = 1'b1;
                pin_out = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_sync_responder_chk.sv
module dbg_sync_responder_chk #(
    parameter int PULSE_CYCLES = 128
) (
    input logic clk,
    input logic rst_n,
    input logic pin_oe,
    input logic pin_out,
    input logic sync_seen
);
    localparam int PW = $clog2(PULSE_CYCLES + 2);

    logic [PW-1:0] low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= '0;
        end else if (pin_oe && !pin_out) begin
            if (low_len != {PW{1'b1}}) low_len <= low_len + 1'b1;
        end else begin
            low_len <= '0;
        end
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen |=> !sync_seen);

    // R4
    no_drive_after_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen |=> !pin_oe);

    // R6
    pulse_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> !pin_out);

    // R6
    pulse_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_out) |-> (low_len == PW'(PULSE_CYCLES)));

    // R7
    speedup_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_out) |=> !pin_oe);

    // R8
    quiet_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !sync_seen);
endmodule

bind dbg_sync_responder dbg_sync_responder_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .sync_seen (sync_seen)
);

// File: tb/tb_dbg_sync_responder.sv
module tb_dbg_sync_responder;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;
    localparam int G = 4;
    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic pin_oe, pin_out, sync_seen;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_sync_responder #(.DETECT_CYCLES(D), .GUARD_CYCLES(G), .PULSE_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .sync_seen(sync_seen)
    );

    function automatic string phase_tag(int t, int w, bit det, int mode);
        if (mode != 0)   return "R8";
        if (!det)        return "R2";
        if (t <= w)      return "R4";
        if (t <= w + G)  return "R5";
        if (t <= w+G+P)  return "R6";
        return "R7";
    endfunction

    // mode 0: quiet host, 1: host holds line low during response, 2: host toggles
    task automatic run_trial(input int len, input int mode);
        bit det = (len >= D);
        int w = (len + 1 > D + 2) ? len + 1 : D + 2;
        int last = det ? w + G + P + 4 : len + 4;
        bit bs = 0, be = 0, bv = 0;
        for (int t = 1; t <= last; t++) begin
            bit ex_s, ex_e, ex_v, host;
            host = (t > len);
            if (det && mode == 1 && t >= w + 1 && t <= w + G + P) host = 1'b0;
            if (det && mode == 2 && t >= w + 1 && t <= w + G + P) host = t[0];
            @(posedge clk); #1 line_in = host;
            @(negedge clk);
            ex_s = det && (t == D + 1);
            ex_e = det && (t >= w + G + 1) && (t <= w + G + P + 1);
            ex_v = (t == w + G + P + 1);
            if (sync_seen !== ex_s && !bs) begin
                bs = 1;
                $display("FAIL %s sync_seen len=%0d mode=%0d t=%0d actual=%0b expected=%0b",
                         det ? (mode != 0 ? "R8" : "R3") : "R2", len, mode, t, sync_seen, ex_s);
            end
            if (pin_oe !== ex_e && !be) begin
                be = 1;
                $display("FAIL %s pin_oe len=%0d mode=%0d t=%0d actual=%0b expected=%0b",
                         phase_tag(t, w, det, mode), len, mode, t, pin_oe, ex_e);
            end
            if (ex_e && pin_out !== ex_v && !bv) begin
                bv = 1;
                $display("FAIL %s pin_out len=%0d mode=%0d t=%0d actual=%0b expected=%0b",
                         phase_tag(t, w, det, mode), len, mode, t, pin_out, ex_v);
            end
        end
        tests += 3;
        fails += int'(bs) + int'(be) + int'(bv);
    endtask

    // R9: two runs of D-1 lows split by one high sample
    task automatic run_gap();
        bit bad = 0;
        for (int t = 1; t <= 2 * D + 4; t++) begin
            @(posedge clk); #1 line_in = !((t <= D - 1) || (t >= D + 1 && t <= 2 * D - 1));
            @(negedge clk);
            if ((sync_seen !== 1'b0 || pin_oe !== 1'b0) && !bad) begin
                bad = 1;
                $display("FAIL R9 t=%0d actual sync=%0b oe=%0b expected sync=0 oe=0",
                         t, sync_seen, pin_oe);
            end
        end
        tests++;
        if (bad) fails++;
    endtask

    task automatic check_reset_outputs(input string where);
        tests++;
        if (pin_oe !== 1'b0 || sync_seen !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s actual oe=%0b sync=%0b expected oe=0 sync=0",
                     where, pin_oe, sync_seen);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        line_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs("in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check_reset_outputs("after release");

        for (int len = 1; len <= D + 5; len++) run_trial(len, 0);
        run_trial(D + 20, 0);
        run_trial(D, 1);
        run_trial(D + 3, 1);
        run_trial(D, 2);
        run_trial(D + 2, 2);
        run_gap();
        run_trial(D - 1, 0);

        // R1: asynchronous reset in the middle of the low pulse
        for (int t = 1; t <= D + 2 + G + 3; t++) begin
            @(posedge clk); #1 line_in = (t > D);
        end
        #1 rst_n = 1'b0;
        @(negedge clk);
        check_reset_outputs("mid-pulse");
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check_reset_outputs("after mid-pulse release");
        run_trial(D, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule